// File: doc/BRIEF.md
# Polled Receive Bus Slave Interface

This block sits on the PHY side of a shared receive bus where the link layer pulls the data. It serves four consecutive port addresses starting at a programmable base, so several PHY devices can share one bus. The link layer drives a 5-bit address and an active-low enable. Every cycle the block answers a poll of one of its own ports with a registered packet-available flag. A selection is taken from the address in the first cycle the enable goes low. While the enable stays low, the block then moves words from the selected port's receive FIFO onto a 32-bit data bus.

Each port has a direct available flag built from the FIFO's byte occupancy, a programmable level, and an end-of-packet-present indication. Words come from a show-ahead FIFO read interface: the head word of the requested port is visible in the same cycle and is popped by the read request. Along with each word the block drives start, end, error, valid, a 2-bit modulus and odd parity. The block does not contain pad drivers. It produces one output enable for the data bus group and one for the polled flag, and a bus output reads zero whenever its enable is low.

Top module: `rx_poll_slave`

## Requirements
- R1: The direct flag of a port is high when its FIFO occupancy in bytes exceeds `cfg_level` or the FIFO holds an end of packet. It is low when the occupancy is zero, and low when occupancy is at or below the level with no end of packet.
- R2: One clock after an address in `[cfg_base, cfg_base+3]` is presented, `poll_avail_oe` is 1 and `poll_avail` equals the direct flag of port (address − base). For any other address, both are 0. `poll_avail` is never 1 while its enable is 0.
- R3: The address is sampled only in a cycle where `link_en_n` is 0 and was 1 in the previous cycle. An in-range address selects port (address − base). An out-of-range address deselects the device. Address changes while the enable stays low have no effect.
- R4: `rx_bus_oe` is 1 in the cycle after a cycle in which `link_en_n` was 0 and the device was selected, and 0 otherwise. While it is 0, every bus output reads 0.
- R5: In each cycle that is enabled and selected, the block issues one read of the selected port (`fifo_rd_port`) if that FIFO is not empty and no end of packet has been delivered since selection. The word appears on `rx_data` in the next cycle with `rx_val` = 1. A read is never issued to an empty FIFO.
- R6: In a cycle after one with no read, `rx_val`, `rx_sop`, `rx_eop`, `rx_err` and `rx_mod` are all 0. This also applies when the FIFO runs dry in mid-packet while selected.
- R7: `rx_sop` and `rx_eop` copy the FIFO word's start and end marks. On the end word, `rx_mod` copies the FIFO modulus: 0 means four valid bytes, and 1 to 3 mean that many valid bytes counted from bit 31 down. `rx_err` copies the FIFO error mark. On words that are not end words, both `rx_mod` and `rx_err` are 0.
- R8: On every valid word, the XOR of `rx_data` and `rx_par` is 1 (odd parity over all 32 data bits).
- R9: After an end-of-packet word is read, no further read is issued until a new selection, even if the FIFO holds more data.
- R10: During and just after reset, both output enables, `rx_val` and `fifo_rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 5 | First of the four port addresses served |
| cfg_level | input | OCC_W | Byte level for the direct flag |
| link_addr | input | 5 | Poll / select address from the link layer |
| link_en_n | input | 1 | Active-low transfer enable |
| port_occ | input | NPORT*OCC_W | Per-port FIFO occupancy in bytes |
| port_has_eop | input | NPORT | Per-port end-of-packet-present flag |
| fifo_rd_req | output | 1 | Pop the head word of `fifo_rd_port` |
| fifo_rd_port | output | PORT_W | Port being read |
| fifo_rd_data | input | 32 | Head word data of the requested port |
| fifo_rd_sop | input | 1 | Head word is a packet start |
| fifo_rd_eop | input | 1 | Head word is a packet end |
| fifo_rd_err | input | 1 | Packet error mark on head word |
| fifo_rd_mod | input | 2 | Valid-byte count of head word |
| port_avail | output | NPORT | Direct available flag per port |
| poll_avail | output | 1 | Polled available flag |
| poll_avail_oe | output | 1 | Output enable for `poll_avail` |
| rx_data | output | 32 | Receive data word |
| rx_par | output | 1 | Odd parity over `rx_data` |
| rx_sop | output | 1 | Start of packet |
| rx_eop | output | 1 | End of packet |
| rx_err | output | 1 | Packet error |
| rx_val | output | 1 | Data bus valid |
| rx_mod | output | 2 | Valid bytes in the end word |
| rx_bus_oe | output | 1 | Output enable for the data bus group |

## Verification
The bench selects a port whose FIFO holds a second packet behind the first. A design that ignored the end-of-packet stop would stream the second packet as unexpected words, and the count of occupied ports would change. It starves a selected port in mid-packet, where a design that kept `rx_val` high would replay a stale word. It moves the address while the enable stays low, so a design that re-sampled the address would switch ports. It also selects an address outside the window, where a design with a loose address compare would drive the bus. Non-end words carry nonzero modulus and error marks, so a design that fails to gate them shows wrong flags. The base is also moved to the top of the address space, where a wrapping compare would claim low addresses.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned MOD_W  = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BUS_W-1:0]  word_t;
  typedef logic [MOD_W-1:0]  mod_t;

  // odd parity: the returned bit makes the total count of ones odd
  function automatic logic odd_par(input word_t d);
    return ~(^d);
  endfunction

  // distance of an address above the window base, with a borrow bit on top
  function automatic logic [ADDR_W:0] addr_offset(input addr_t a, input addr_t b);
    return {1'b0, a} - {1'b0, b};
  endfunction
endpackage

// File: rtl/rxb_flag_gen.sv
module rxb_flag_gen
  import rxb_pkg::*;
#(
  parameter int unsigned NPORT = 4,
  parameter int unsigned OCC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT*OCC_W-1:0] occ,
  input  logic [NPORT-1:0]       has_eop,
  input  logic [OCC_W-1:0]       level,
  output logic [NPORT-1:0]       direct,
  output logic [NPORT-1:0]       nonempty
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [OCC_W-1:0] bytes;
    logic             above;
    assign bytes       = occ[i*OCC_W +: OCC_W];
    assign nonempty[i] = |bytes;
    assign above       = bytes > level;
    assign direct[i]   = nonempty[i] & (above | has_eop[i]);

    // R1
    empty_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bytes == '0) |-> !direct[i]);
  end
endmodule

// File: rtl/rxb_addr_dec.sv
module rxb_addr_dec
  import rxb_pkg::*;
#(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned PORT_W = 2
) (
  input  addr_t             addr,
  input  addr_t             base,
  output logic              hit,
  output logic [PORT_W-1:0] idx
);
  localparam int unsigned OFF_W = ADDR_W + 1;
  logic [OFF_W-1:0] off;

  assign off = addr_offset(addr, base);
  assign hit = !off[OFF_W-1] && (off < OFF_W'(NPORT));
  assign idx = off[PORT_W-1:0];
endmodule

// File: rtl/rxb_poll_resp.sv
module rxb_poll_resp #(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [PORT_W-1:0] idx,
  input  logic [NPORT-1:0]  direct,
  output logic              pa,
  output logic              pa_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa    <= 1'b0;
      pa_oe <= 1'b0;
    end else begin
      pa_oe <= hit;
      pa    <= hit & direct[idx];
    end
  end

  // R2
  poll_flag_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa |-> pa_oe);
endmodule

// File: rtl/rxb_xfer.sv
module rxb_xfer
  import rxb_pkg::*;
#(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              hit,
  input  logic [PORT_W-1:0] idx,
  input  logic [NPORT-1:0]  nonempty,
  output logic              rd_req,
  output logic [PORT_W-1:0] rd_port,
  input  word_t             in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_err,
  input  mod_t              in_mod,
  output logic              oe,
  output word_t             data,
  output logic              par,
  output logic              sop,
  output logic              eop,
  output logic              err,
  output logic              val,
  output mod_t              mod
);
  logic              en_n_q;
  logic              sel_q;
  logic [PORT_W-1:0] port_q;
  logic              done_q;

  // named internal events
  logic              sel_evt;
  logic              sel_now;
  logic [PORT_W-1:0] port_now;
  logic              done_now;

  assign sel_evt = en_n_q & ~en_n;

  always_comb begin
    sel_now  = sel_evt ? hit : sel_q;
    port_now = sel_evt ? idx : port_q;
    done_now = sel_evt ? 1'b0 : done_q;
  end

  assign rd_port = port_now;
  assign rd_req  = rst_n & ~en_n & sel_now & ~done_now & nonempty[port_now];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_q <= 1'b1;
      sel_q  <= 1'b0;
      port_q <= '0;
      done_q <= 1'b0;
      oe     <= 1'b0;
      val    <= 1'b0;
      data   <= '0;
      par    <= 1'b1;
      sop    <= 1'b0;
      eop    <= 1'b0;
      err    <= 1'b0;
      mod    <= '0;
    end else begin
      en_n_q <= en_n;
      sel_q  <= sel_now;
      port_q <= port_now;
      done_q <= done_now | (rd_req & in_eop);
      oe     <= ~en_n & sel_now;
      val    <= rd_req;
      if (rd_req) begin
        data <= in_data;
        par  <= odd_par(in_data);
        sop  <= in_sop;
        eop  <= in_eop;
        err  <= in_eop & in_err;
        mod  <= in_eop ? in_mod : '0;
      end else begin
        sop <= 1'b0;
        eop <= 1'b0;
        err <= 1'b0;
        mod <= '0;
      end
    end
  end

  // R4
  bus_drive_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(!en_n));

  // R5
  no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> nonempty[rd_port]);

  // R9
  stop_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val && eop && !sel_evt) |-> !rd_req);

  // R6
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sop || eop || err || (mod != '0)) |-> val);

  // R7
  mod_on_end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod != '0 || err) |-> eop);

  // R8
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val |-> (^{data, par}));
endmodule

// File: rtl/rx_poll_slave.sv
module rx_poll_slave
  import rxb_pkg::*;
#(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned OCC_W  = 8,
  localparam int unsigned PORT_W = $clog2(NPORT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             cfg_base,
  input  logic [OCC_W-1:0]       cfg_level,
  input  logic [4:0]             link_addr,
  input  logic                   link_en_n,
  input  logic [NPORT*OCC_W-1:0] port_occ,
  input  logic [NPORT-1:0]       port_has_eop,
  output logic                   fifo_rd_req,
  output logic [PORT_W-1:0]      fifo_rd_port,
  input  logic [31:0]            fifo_rd_data,
  input  logic                   fifo_rd_sop,
  input  logic                   fifo_rd_eop,
  input  logic                   fifo_rd_err,
  input  logic [1:0]             fifo_rd_mod,
  output logic [NPORT-1:0]       port_avail,
  output logic                   poll_avail,
  output logic                   poll_avail_oe,
  output logic [31:0]            rx_data,
  output logic                   rx_par,
  output logic                   rx_sop,
  output logic                   rx_eop,
  output logic                   rx_err,
  output logic                   rx_val,
  output logic [1:0]             rx_mod,
  output logic                   rx_bus_oe
);
  logic [NPORT-1:0]  nonempty;
  logic              addr_hit;
  logic [PORT_W-1:0] addr_idx;
  logic              oe_q;
  word_t             data_q;
  logic              par_q, sop_q, eop_q, err_q, val_q;
  mod_t              mod_q;

  rxb_flag_gen #(.NPORT(NPORT), .OCC_W(OCC_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .occ(port_occ), .has_eop(port_has_eop),
    .level(cfg_level), .direct(port_avail), .nonempty(nonempty)
  );

  rxb_addr_dec #(.NPORT(NPORT), .PORT_W(PORT_W)) u_dec (
    .addr(link_addr), .base(cfg_base), .hit(addr_hit), .idx(addr_idx)
  );

  rxb_poll_resp #(.NPORT(NPORT), .PORT_W(PORT_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .hit(addr_hit), .idx(addr_idx),
    .direct(port_avail), .pa(poll_avail), .pa_oe(poll_avail_oe)
  );

  rxb_xfer #(.NPORT(NPORT), .PORT_W(PORT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .en_n(link_en_n), .hit(addr_hit), .idx(addr_idx),
    .nonempty(nonempty), .rd_req(fifo_rd_req), .rd_port(fifo_rd_port),
    .in_data(fifo_rd_data), .in_sop(fifo_rd_sop), .in_eop(fifo_rd_eop),
    .in_err(fifo_rd_err), .in_mod(fifo_rd_mod),
    .oe(oe_q), .data(data_q), .par(par_q), .sop(sop_q), .eop(eop_q),
    .err(err_q), .val(val_q), .mod(mod_q)
  );

  // bus group reads zero whenever it is not driven
  assign rx_bus_oe = oe_q;
  assign rx_data   = oe_q ? data_q : '0;
  assign rx_par    = oe_q & par_q;
  assign rx_sop    = oe_q & sop_q;
  assign rx_eop    = oe_q & eop_q;
  assign rx_err    = oe_q & err_q;
  assign rx_val    = oe_q & val_q;
  assign rx_mod    = oe_q ? mod_q : '0;

  // R10
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |-> (!fifo_rd_req && !rx_bus_oe && !poll_avail_oe && !rx_val));
endmodule

// File: tb/rx_poll_slave_test.sv
module rx_poll_slave_test;
  localparam int NPORT = 4;
  localparam int OCC_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic [4:0]         cfg_base = 5'd8;
  logic [OCC_W-1:0]   cfg_level = 8'd7;
  logic [4:0]         link_addr = '0;
  logic               link_en_n = 1'b1;
  logic [NPORT*OCC_W-1:0] port_occ;
  logic [NPORT-1:0]   port_has_eop;
  logic               fifo_rd_req;
  logic [1:0]         fifo_rd_port;
  logic [31:0]        fifo_rd_data;
  logic               fifo_rd_sop, fifo_rd_eop, fifo_rd_err;
  logic [1:0]         fifo_rd_mod;
  logic [NPORT-1:0]   port_avail;
  logic               poll_avail, poll_avail_oe;
  logic [31:0]        rx_data;
  logic               rx_par, rx_sop, rx_eop, rx_err, rx_val, rx_bus_oe;
  logic [1:0]         rx_mod;

  rx_poll_slave #(.NPORT(NPORT), .OCC_W(OCC_W)) uut (.*);

  // FIFO model: entry = {data[31:0], sop, eop, err, mod[1:0]}
  logic [36:0] mem [NPORT][16];
  int hd [NPORT];
  int tl [NPORT];
  logic [36:0] exp_q [$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  initial begin
    for (int p = 0; p < NPORT; p++) begin
      hd[p] = 0;
      tl[p] = 0;
      for (int k = 0; k < 16; k++) mem[p][k] = '0;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      port_occ[p*OCC_W +: OCC_W] = OCC_W'((tl[p] - hd[p]) * 4);
      port_has_eop[p] = 1'b0;
      for (int k = hd[p]; k < tl[p]; k++)
        if (mem[p][k & 15][3]) port_has_eop[p] = 1'b1;
    end
  end

  always_comb begin
    logic [36:0] h;
    h = mem[fifo_rd_port][hd[fifo_rd_port] & 15];
    fifo_rd_data = h[36:5];
    fifo_rd_sop  = h[4];
    fifo_rd_eop  = h[3];
    fifo_rd_err  = h[2];
    fifo_rd_mod  = h[1:0];
  end

  always @(posedge clk) if (rst_n && fifo_rd_req) hd[fifo_rd_port] <= hd[fifo_rd_port] + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int p, input logic [31:0] d, input bit s, input bit e,
                      input bit r, input logic [1:0] m);
    mem[p][tl[p] & 15] = {d, s, e, r, m};
    tl[p] = tl[p] + 1;
  endtask

  // driver side of the scoreboard: queue the next n words of port p
  task automatic expect_words(input int p, input int off, input int n);
    for (int k = 0; k < n; k++) begin
      logic [36:0] e;
      e = mem[p][(hd[p] + off + k) & 15];
      exp_q.push_back({e[36:3], e[3] & e[2], e[3] ? e[1:0] : 2'b00});
    end
  endtask

  task automatic select(input logic [4:0] a);
    @(negedge clk);
    link_addr = a;
    link_en_n = 1'b0;
  endtask

  task automatic release_bus();
    @(negedge clk);
    link_en_n = 1'b1;
  endtask

  task automatic poll(input logic [4:0] a, input bit exp_oe, input bit exp_pa, input string tag);
    @(negedge clk);
    link_addr = a;
    @(negedge clk);
    chk(poll_avail_oe == exp_oe, "R2", {tag, " poll enable"}, 64'(poll_avail_oe), 64'(exp_oe));
    chk(poll_avail == exp_pa, "R2", {tag, " poll flag"}, 64'(poll_avail), 64'(exp_pa));
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_val) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "word with nothing expected", 64'(rx_data), 64'(0));
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e[36:5], "R5", "word data", 64'(rx_data), 64'(e[36:5]));
        chk({rx_sop, rx_eop, rx_err, rx_mod} == e[4:0], "R7", "sop/eop/err/mod",
            64'({rx_sop, rx_eop, rx_err, rx_mod}), 64'(e[4:0]));
        chk(rx_par == ~(^rx_data), "R8", "odd parity", 64'(rx_par), 64'(~(^rx_data)));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!fifo_rd_req && !rx_bus_oe && !poll_avail_oe, "R10", "quiet in reset",
        64'({fifo_rd_req, rx_bus_oe, poll_avail_oe}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_val && !rx_bus_oe && !poll_avail_oe && !fifo_rd_req, "R10", "quiet after reset",
        64'({rx_val, rx_bus_oe, poll_avail_oe, fifo_rd_req}), 64'(0));

    // R1: level 7 bytes; port0 4 bytes then 8 bytes, port1 one end word
    chk(port_avail == 4'b0000, "R1", "all empty", 64'(port_avail), 64'(0));
    push(0, 32'hA1B2C3D4, 1, 0, 1, 2'd2);
    #1 chk(port_avail[0] == 1'b0, "R1", "4 bytes at level 7", 64'(port_avail[0]), 64'(0));
    push(0, 32'h00000003, 0, 0, 1, 2'd1);
    push(1, 32'hFFFF0000, 1, 1, 0, 2'd2);
    #1 chk(port_avail == 4'b0011, "R1", "above level or eop", 64'(port_avail), 64'(3));

    // R2 polls with base 8
    poll(5'd9,  1, 1, "port1");
    poll(5'd10, 1, 0, "port2 empty");
    poll(5'd3,  0, 0, "below window");
    poll(5'd12, 0, 0, "above window");

    // R3 R4 R5 R7 R8: burst from port0, address moved while enabled
    push(0, 32'h80000001, 0, 1, 1, 2'd3);
    expect_words(0, 0, 3);
    select(5'd8);
    @(negedge clk);
    chk(rx_bus_oe == 1'b1, "R4", "driven after select", 64'(rx_bus_oe), 64'(1));
    link_addr = 5'd9;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all port0 words seen", 64'(exp_q.size()), 64'(0));
    chk(port_avail[1] == 1'b1, "R3", "port1 untouched", 64'(port_avail[1]), 64'(1));
    chk(port_avail[0] == 1'b0, "R1", "drained port low", 64'(port_avail[0]), 64'(0));
    release_bus();
    @(negedge clk);
    chk(rx_bus_oe == 1'b0 && rx_data == 32'h0, "R4", "released bus quiet",
        64'({rx_bus_oe, rx_data}), 64'(0));

    // R9: two packets in port2, only the first goes out
    push(2, 32'h11112222, 1, 0, 0, 2'd3);
    push(2, 32'h33334444, 0, 1, 0, 2'd2);
    push(2, 32'h55556666, 1, 1, 1, 2'd0);
    expect_words(2, 0, 2);
    select(5'd10);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "first packet only", 64'(exp_q.size()), 64'(0));
    chk(rx_val == 1'b0, "R9", "held after eop", 64'(rx_val), 64'(0));
    chk(port_avail[2] == 1'b1, "R9", "second packet kept", 64'(port_avail[2]), 64'(1));
    release_bus();
    expect_words(2, 0, 1);
    select(5'd10);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "second packet after reselect", 64'(exp_q.size()), 64'(0));
    release_bus();

    // R6: port3 runs dry mid-packet
    push(3, 32'hDEADBEEF, 1, 0, 1, 2'd3);
    expect_words(3, 0, 1);
    select(5'd11);
    repeat (3) @(negedge clk);
    chk(rx_val == 1'b0 && rx_sop == 1'b0, "R6", "no valid when dry",
        64'({rx_val, rx_sop}), 64'(0));
    chk(rx_bus_oe == 1'b1, "R4", "still driven when dry", 64'(rx_bus_oe), 64'(1));
    push(3, 32'h12345678, 0, 1, 0, 2'd0);
    expect_words(3, 0, 1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "resume after refill", 64'(exp_q.size()), 64'(0));
    release_bus();

    // R3: out-of-window select leaves the bus alone
    select(5'd20);
    repeat (3) @(negedge clk);
    chk(rx_bus_oe == 1'b0, "R3", "other device selected", 64'(rx_bus_oe), 64'(0));
    chk(port_avail[1] == 1'b1, "R3", "no read on foreign select", 64'(port_avail[1]), 64'(1));
    release_bus();

    // R2 R3 with base near the top of the address space
    @(negedge clk);
    cfg_base = 5'd28;
    poll(5'd31, 1, 0, "top port3");
    poll(5'd27, 0, 0, "just below base");
    poll(5'd0,  0, 0, "no wrap");
    poll(5'd29, 1, 1, "top port1");
    link_en_n = 1'b1;
    expect_words(1, 0, 1);
    select(5'd29);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "select at high base", 64'(exp_q.size()), 64'(0));
    release_bus();
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule